// File: doc/BRIEF.md
# Two-Phase Mesh Barrier Synchroniser

This block sits in one node of a mesh of compute nodes. It moves the node's shared algorithmic time-step forward without any global clock. The node works on step t until its compartment pipeline reports that it has finished. The synchroniser then runs a barrier with its direct neighbours only. Each neighbour link carries small barrier tokens, and the barrier has two phases.

In phase one the node announces that it is done and waits for two things: its own spike egress must be empty, and every connected neighbour must have sent the same announcement. When phase one closes, every spike of step t has left every node around it. In phase two the node sends an advance notice. It moves to step t+1 once every connected neighbour has sent an advance notice too. A management controller can ask for a preemption window. The window opens between the two phases, and the barrier waits there while the request is held.

Each token carries the low bit of its step number. Stale tokens can therefore be told apart from tokens that belong to the current step. A phase-one token that a fast neighbour sends early for the next step is kept until that step begins.

Top module: `mesh_barrier_sync`

## Requirements
- R1: While reset is asserted, step_count is 0, tok_out_valid is 0 and preempt_grant is 0. One cycle after reset is released, step_begin pulses for one cycle with step_count equal to 0.
- R2: The cycle after upd_done is sampled high in the working state, the block sends a phase-one token for one cycle. The token goes only on the ports whose port_connected bit is 1 (bit 0 N, 1 E, 2 S, 3 W). It has tok_out_phase = 0 and tok_out_parity = step_count[0].
- R3: Phase-two tokens (tok_out_phase = 1) go out on the connected ports only after both of these hold: egress_empty has been high, and a current-parity phase-one token has been received on every connected port.
- R4: A port whose port_connected bit is 0 counts as having delivered both of its tokens. With no port connected, a step finishes on its own after upd_done.
- R5: Suppose preempt_req is high when phase one completes. Then preempt_grant rises and no phase-two token is sent. The phase-two tokens go out the cycle after preempt_req is seen low with egress_empty high, and at that point preempt_grant falls.
- R6: step_count increments by one, with a one-cycle step_begin pulse, only after a current-parity phase-two token has arrived on every connected port.
- R7: A received token whose tok_in_parity differs from step_count[0] is ignored. There is one exception: a phase-one token that arrives after this node has sent its phase-two tokens is kept and counts for the next step.
- R8: step_count is STEP_W bits wide (default 16) and wraps from its maximum value to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| port_connected | input | NPORT | 1 = neighbour present on that port (bit 0 N, 1 E, 2 S, 3 W) |
| upd_done | input | 1 | Compartment updates for the current step finished |
| egress_empty | input | 1 | Local spike egress holds no spikes |
| preempt_req | input | 1 | Management preemption request |
| tok_in_valid | input | NPORT | Token arriving on each port |
| tok_in_phase | input | NPORT | Per-port token phase: 0 phase one, 1 phase two |
| tok_in_parity | input | NPORT | Per-port token step parity |
| tok_out_valid | output | NPORT | Token sent on each port |
| tok_out_phase | output | 1 | Phase of the sent tokens |
| tok_out_parity | output | 1 | Step parity of the sent tokens |
| preempt_grant | output | 1 | Preemption window open |
| step_count | output | STEP_W | Current time-step |
| step_begin | output | 1 | One-cycle pulse when a step starts |

## Verification
The hardest case to reach from the ports is a neighbour that runs one phase ahead. Its next-step phase-one token lands while this node still waits for phase-two tokens of the current step. That token has the wrong parity, but it must be kept rather than dropped. The stimulus sends such tokens right after the node's phase-two tokens appear. It then pulses upd_done and expects phase one and phase two to follow back to back, with no further input. Stale-parity tokens sent during phase one are also shown to leave the node waiting. Those two cases are the two sides of the same parity rule.

// File: rtl/mbs_pkg.sv
// Package: shared types for the mesh barrier synchroniser.
// Assumes: token phase 0 is phase one (drain), 1 is phase two (advance).
package mbs_pkg;
    typedef enum logic [2:0] {
        ST_IDLE     = 3'd0,
        ST_UPDATING = 3'd1,
        ST_PH1      = 3'd2,
        ST_PREEMPT  = 3'd3,
        ST_PH2      = 3'd4
    } mbs_state_e;

    localparam logic PH_ONE = 1'b0;
    localparam logic PH_TWO = 1'b1;
endpackage

// File: rtl/mbs_token_rx.sv
// Token receiver: records, per port, which barrier tokens have arrived.
// There is one flag bank per step parity. The current bank is indexed
// by cur_parity. The other bank takes only early phase-one tokens, and
// only while accept_early is high (this node already sent phase two).
// Unconnected ports count as delivered.
// Assumes clear_bank is a one-cycle strobe at the step advance.
module mbs_token_rx #(
    parameter int NPORT = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NPORT-1:0] port_connected,
    input  logic [NPORT-1:0] tok_in_valid,
    input  logic [NPORT-1:0] tok_in_phase,
    input  logic [NPORT-1:0] tok_in_parity,
    input  logic             cur_parity,
    input  logic             accept_early,
    input  logic             clear_bank,
    output logic             ph1_all,
    output logic             ph2_all
);
    import mbs_pkg::*;

    logic [NPORT-1:0] have_p1;
    logic [NPORT-1:0] have_p2;

    for (genvar i = 0; i < NPORT; i++) begin : g_port
        logic [1:0] p1_bank;
        logic [1:0] p2_bank;
        logic       tok_cur;
        logic       tok_early;

        // Classify the arriving token as current-step or early next-step.
        always_comb begin
            tok_cur   = tok_in_valid[i] && (tok_in_parity[i] == cur_parity);
            tok_early = tok_in_valid[i] && (tok_in_parity[i] != cur_parity)
                        && (tok_in_phase[i] == PH_ONE) && accept_early;
        end

        // Set arrival flags and clear the finished bank on advance.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                p1_bank <= '0;
                p2_bank <= '0;
            end else begin
                if (clear_bank) begin
                    p1_bank[cur_parity] <= 1'b0;
                    p2_bank[cur_parity] <= 1'b0;
                end else if (tok_cur) begin
                    if (tok_in_phase[i] == PH_ONE) p1_bank[cur_parity] <= 1'b1;
                    else                           p2_bank[cur_parity] <= 1'b1;
                end
                if (tok_early) p1_bank[!cur_parity] <= 1'b1;
            end
        end

        // A port is satisfied when its token came or it has no neighbour.
        always_comb begin
            have_p1[i] = p1_bank[cur_parity] || !port_connected[i];
            have_p2[i] = p2_bank[cur_parity] || !port_connected[i];
        end
    end

    // Phase is complete when every port is satisfied.
    always_comb begin
        ph1_all = &have_p1;
        ph2_all = &have_p2;
    end
endmodule

// File: rtl/mbs_ctrl.sv
// Barrier sequencer: IDLE, UPDATING, PH1, optional PREEMPT, PH2, then
// the step advance. It owns the time-step counter, the step_begin pulse
// and the preemption grant. It issues one-cycle send strobes that the
// transmitter registers.
// Assumes ph1_all / ph2_all come from registered arrival flags.
module mbs_ctrl #(
    parameter int STEP_W = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               upd_done,
    input  logic               egress_empty,
    input  logic               preempt_req,
    input  logic               ph1_all,
    input  logic               ph2_all,
    output logic               send_ph1,
    output logic               send_ph2,
    output logic               advance,
    output logic               accept_early,
    output logic               preempt_grant,
    output logic [STEP_W-1:0]  step_count,
    output logic               step_begin
);
    import mbs_pkg::*;

    mbs_state_e state_q, state_d;
    logic       grant_d;

    // Next-state decision and the strobes that go with each transition.
    always_comb begin
        state_d  = state_q;
        send_ph1 = 1'b0;
        send_ph2 = 1'b0;
        advance  = 1'b0;
        grant_d  = preempt_grant;
        unique case (state_q)
            ST_IDLE: state_d = ST_UPDATING;
            ST_UPDATING: begin
                if (upd_done) begin
                    state_d  = ST_PH1;
                    send_ph1 = 1'b1;
                end
            end
            ST_PH1: begin
                if (egress_empty && ph1_all) begin
                    if (preempt_req) begin
                        state_d = ST_PREEMPT;
                        grant_d = 1'b1;
                    end else begin
                        state_d  = ST_PH2;
                        send_ph2 = 1'b1;
                    end
                end
            end
            ST_PREEMPT: begin
                if (!preempt_req && egress_empty) begin
                    state_d  = ST_PH2;
                    send_ph2 = 1'b1;
                    grant_d  = 1'b0;
                end
            end
            ST_PH2: begin
                if (ph2_all) begin
                    state_d = ST_UPDATING;
                    advance = 1'b1;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // Early next-step tokens are legal only once phase two was sent.
    always_comb accept_early = (state_q == ST_PH2);

    // State, grant, counter and start pulse registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q       <= ST_IDLE;
            preempt_grant <= 1'b0;
            step_count    <= '0;
            step_begin    <= 1'b0;
        end else begin
            state_q       <= state_d;
            preempt_grant <= grant_d;
            step_begin    <= advance || (state_q == ST_IDLE);
            if (advance) step_count <= step_count + 1'b1;
        end
    end
endmodule

// File: rtl/mbs_token_tx.sv
// Token transmitter: registers a one-cycle token on every connected port
// when the sequencer strobes phase one or phase two.
// Assumes the two strobes are never high together.
module mbs_token_tx #(
    parameter int NPORT = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NPORT-1:0] port_connected,
    input  logic             send_ph1,
    input  logic             send_ph2,
    input  logic             cur_parity,
    output logic [NPORT-1:0] tok_out_valid,
    output logic             tok_out_phase,
    output logic             tok_out_parity
);
    import mbs_pkg::*;

    // Drive the token pulse, its phase and the step parity.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tok_out_valid  <= '0;
            tok_out_phase  <= PH_ONE;
            tok_out_parity <= 1'b0;
        end else begin
            tok_out_valid <= (send_ph1 || send_ph2) ? port_connected : '0;
            if (send_ph1 || send_ph2) begin
                tok_out_phase  <= send_ph2 ? PH_TWO : PH_ONE;
                tok_out_parity <= cur_parity;
            end
        end
    end
endmodule

// File: rtl/mesh_barrier_sync.sv
// Top: one mesh node's two-phase barrier synchroniser. It exchanges
// barrier tokens with up to NPORT neighbours and advances the local
// time-step once the drain phase and the advance phase both complete.
// Assumes port_connected is static while a token is in flight.
module mesh_barrier_sync #(
    parameter int NPORT  = 4,
    parameter int STEP_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NPORT-1:0]  port_connected,
    input  logic              upd_done,
    input  logic              egress_empty,
    input  logic              preempt_req,
    input  logic [NPORT-1:0]  tok_in_valid,
    input  logic [NPORT-1:0]  tok_in_phase,
    input  logic [NPORT-1:0]  tok_in_parity,
    output logic [NPORT-1:0]  tok_out_valid,
    output logic              tok_out_phase,
    output logic              tok_out_parity,
    output logic              preempt_grant,
    output logic [STEP_W-1:0] step_count,
    output logic              step_begin
);
    logic ph1_all, ph2_all;
    logic send_ph1, send_ph2, advance, accept_early;
    logic cur_parity;

    // The step's low bit is the token parity.
    always_comb cur_parity = step_count[0];

    mbs_token_rx #(.NPORT(NPORT)) u_rx (
        .clk           (clk),
        .rst_n         (rst_n),
        .port_connected(port_connected),
        .tok_in_valid  (tok_in_valid),
        .tok_in_phase  (tok_in_phase),
        .tok_in_parity (tok_in_parity),
        .cur_parity    (cur_parity),
        .accept_early  (accept_early),
        .clear_bank    (advance),
        .ph1_all       (ph1_all),
        .ph2_all       (ph2_all)
    );

    mbs_ctrl #(.STEP_W(STEP_W)) u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .upd_done     (upd_done),
        .egress_empty (egress_empty),
        .preempt_req  (preempt_req),
        .ph1_all      (ph1_all),
        .ph2_all      (ph2_all),
        .send_ph1     (send_ph1),
        .send_ph2     (send_ph2),
        .advance      (advance),
        .accept_early (accept_early),
        .preempt_grant(preempt_grant),
        .step_count   (step_count),
        .step_begin   (step_begin)
    );

    mbs_token_tx #(.NPORT(NPORT)) u_tx (
        .clk           (clk),
        .rst_n         (rst_n),
        .port_connected(port_connected),
        .send_ph1      (send_ph1),
        .send_ph2      (send_ph2),
        .cur_parity    (cur_parity),
        .tok_out_valid (tok_out_valid),
        .tok_out_phase (tok_out_phase),
        .tok_out_parity(tok_out_parity)
    );
endmodule

// File: rtl/mbs_checker.sv
// Checker: temporal properties of the barrier synchroniser at its ports.
// It is attached to every instance of the top module by bind.
module mbs_checker #(
    parameter int NPORT  = 4,
    parameter int STEP_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic [NPORT-1:0]  port_connected,
    input logic              egress_empty,
    input logic [NPORT-1:0]  tok_out_valid,
    input logic              tok_out_phase,
    input logic              tok_out_parity,
    input logic              preempt_grant,
    input logic [STEP_W-1:0] step_count,
    input logic              step_begin
);
    // R6
    step_moves_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step_count != $past(step_count)) |-> step_begin);

    // R1
    begin_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        step_begin |=> !step_begin);

    // R2
    edge_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tok_out_valid & ~$past(port_connected)) == '0);

    // R2
    tok_parity_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|tok_out_valid) |-> (tok_out_parity == step_count[0]));

    // R3
    ph2_drained_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((|tok_out_valid) && tok_out_phase) |-> $past(egress_empty));

    // R5
    grant_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        preempt_grant |-> (tok_out_valid == '0));
endmodule

bind mesh_barrier_sync mbs_checker #(.NPORT(NPORT), .STEP_W(STEP_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .port_connected(port_connected),
    .egress_empty  (egress_empty),
    .tok_out_valid (tok_out_valid),
    .tok_out_phase (tok_out_phase),
    .tok_out_parity(tok_out_parity),
    .preempt_grant (preempt_grant),
    .step_count    (step_count),
    .step_begin    (step_begin)
);

// File: tb/mesh_barrier_sync_tb.sv
// Scoreboard bench: the driver queues each expected output event, and
// the monitor compares every event the design produces against the queue.
module mesh_barrier_sync_tb;
    localparam int NP = 4;
    localparam int SW = 4;
    localparam int EW = 1 + NP + 2 + SW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NP-1:0] port_connected = '1;
    logic          upd_done = 1'b0;
    logic          egress_empty = 1'b1;
    logic          preempt_req = 1'b0;
    logic [NP-1:0] tok_in_valid = '0;
    logic [NP-1:0] tok_in_phase = '0;
    logic [NP-1:0] tok_in_parity = '0;
    logic [NP-1:0] tok_out_valid;
    logic          tok_out_phase;
    logic          tok_out_parity;
    logic          preempt_grant;
    logic [SW-1:0] step_count;
    logic          step_begin;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    logic [EW-1:0] exp_q[$];
    string         tag_q[$];

    always #10 clk = ~clk;

    mesh_barrier_sync #(.NPORT(NP), .STEP_W(SW)) u_dut (
        .clk(clk), .rst_n(rst_n), .port_connected(port_connected),
        .upd_done(upd_done), .egress_empty(egress_empty),
        .preempt_req(preempt_req), .tok_in_valid(tok_in_valid),
        .tok_in_phase(tok_in_phase), .tok_in_parity(tok_in_parity),
        .tok_out_valid(tok_out_valid), .tok_out_phase(tok_out_phase),
        .tok_out_parity(tok_out_parity), .preempt_grant(preempt_grant),
        .step_count(step_count), .step_begin(step_begin)
    );

    // Queue one expected output event with its requirement tag.
    task automatic expect_ev(input logic sb, input logic [NP-1:0] v,
                             input logic ph, input logic par,
                             input logic [SW-1:0] st, input string tag);
        exp_q.push_back({sb, v, ph, par, st});
        tag_q.push_back(tag);
    endtask

    // Single direct check with a FAIL line on mismatch.
    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Drive one token cycle on the ports in mask.
    task automatic send(input logic [NP-1:0] mask, input logic ph, input logic par);
        @(negedge clk);
        tok_in_valid  = mask;
        tok_in_phase  = {NP{ph}};
        tok_in_parity = {NP{par}};
        @(negedge clk);
        tok_in_valid  = '0;
    endtask

    task automatic pulse_upd();
        @(negedge clk);
        upd_done = 1'b1;
        @(negedge clk);
        upd_done = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Monitor: compare every output event with the scoreboard head.
    always @(negedge clk) begin
        if (rst_n && (step_begin || (|tok_out_valid))) begin
            logic [EW-1:0] act;
            act = {step_begin, tok_out_valid,
                   (|tok_out_valid) ? tok_out_phase : 1'b0,
                   (|tok_out_valid) ? tok_out_parity : 1'b0, step_count};
            checks++;
            if (exp_q.size() == 0) begin
                errors++;
                $display("FAIL unexpected event actual=%h expected=none", act);
            end else begin
                logic [EW-1:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                if (act !== e) begin
                    errors++;
                    $display("FAIL %s actual=%h expected=%h", t, act, e);
                end
            end
        end
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        // R1 reset values
        idle(3);
        chk(step_count == 0, "R1 step in reset", step_count, 0);
        chk(tok_out_valid == 0, "R1 tokens in reset", tok_out_valid, 0);
        chk(preempt_grant == 0, "R1 grant in reset", preempt_grant, 0);
        expect_ev(1, 4'b0000, 0, 0, 0, "R1 first step_begin");
        rst_n = 1'b1;
        idle(4);

        // R2 phase one on all four ports, R3 hold while egress busy
        expect_ev(0, 4'b1111, 0, 0, 0, "R2 phase-one tokens");
        pulse_upd();
        idle(3);
        egress_empty = 1'b0;
        send(4'b1111, 0, 0);
        idle(6);
        chk(exp_q.size() == 0, "R3 no phase two while egress busy", exp_q.size(), 0);
        expect_ev(0, 4'b1111, 1, 0, 0, "R3 phase-two tokens after drain");
        egress_empty = 1'b1;
        idle(4);

        // R6 step holds until every connected port sent phase two
        send(4'b0111, 1, 0);
        idle(5);
        chk(step_count == 0, "R6 step held with one port missing", step_count, 0);
        expect_ev(1, 4'b0000, 0, 0, 1, "R6 advance to step 1");
        send(4'b1000, 1, 0);
        idle(4);

        // R4 unconnected ports, R7 stale parity ignored
        port_connected = 4'b0101;
        expect_ev(0, 4'b0101, 0, 1, 1, "R4 phase one on connected ports only");
        pulse_upd();
        send(4'b0101, 0, 0);
        idle(6);
        chk(exp_q.size() == 0, "R7 stale tokens ignored", exp_q.size(), 0);
        expect_ev(0, 4'b0101, 1, 1, 1, "R7 phase two after current tokens");
        send(4'b0101, 0, 1);
        idle(4);

        // R7 early next-step phase one kept
        send(4'b0101, 0, 0);
        expect_ev(1, 4'b0000, 0, 0, 2, "R6 advance to step 2");
        send(4'b0101, 1, 1);
        idle(4);
        expect_ev(0, 4'b0101, 0, 0, 2, "R7 phase one step 2");
        expect_ev(0, 4'b0101, 1, 0, 2, "R7 early tokens complete phase one");
        pulse_upd();
        idle(5);
        chk(exp_q.size() == 0, "R7 back-to-back phases seen", exp_q.size(), 0);
        expect_ev(1, 4'b0000, 0, 0, 3, "R6 advance to step 3");
        send(4'b0101, 1, 0);
        idle(4);

        // R5 preemption window
        preempt_req = 1'b1;
        expect_ev(0, 4'b0101, 0, 1, 3, "R5 phase one before preempt");
        pulse_upd();
        send(4'b0101, 0, 1);
        idle(6);
        chk(preempt_grant == 1'b1, "R5 grant raised", preempt_grant, 1);
        chk(exp_q.size() == 0, "R5 no phase two while preempted", exp_q.size(), 0);
        expect_ev(0, 4'b0101, 1, 1, 3, "R5 phase two after release");
        preempt_req = 1'b0;
        idle(3);
        chk(preempt_grant == 1'b0, "R5 grant dropped", preempt_grant, 0);
        expect_ev(1, 4'b0000, 0, 0, 4, "R6 advance to step 4");
        send(4'b0101, 1, 1);
        idle(4);

        // R4 no neighbours at all, R8 counter wrap
        port_connected = 4'b0000;
        for (int s = 4; s < 16; s++) begin
            expect_ev(1, 4'b0000, 0, 0, 4'((s + 1) % 16), "R8 R4 free-running step");
            pulse_upd();
            idle(6);
        end
        chk(step_count == 0, "R8 wrapped to zero", step_count, 0);
        chk(exp_q.size() == 0, "R6 all expected events seen", exp_q.size(), 0);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule